// File: doc/BRIEF.md
# Reset Strap Capture and Shared Pin Sequencer

After reset is released, this block reads a set of configuration straps from pins that later serve other purposes. It keeps the captured values until the next reset and decodes them into the hub's configuration: gang or per-port power mode, the polarity of the power-switch enable, the number of downstream ports, a non-removable flag for each port and the reference clock choice. A cycle counter sets two moments after reset release. The first is the end of the sampling window, when every strap is latched together. The second is the point where the gang strap pin stops acting as an input and starts driving a suspend indicator.

The suspend indicator takes its polarity from the gang strap that the pin itself supplied. The block also turns per-port power requests into enable outputs in the strapped polarity, and folds power and overcurrent handling onto port 1 when gang mode is selected. It holds the LED pads as inputs until sampling is done, and keeps every LED dark while the hub is globally suspended. The pad electrical behaviour and the clock generation are outside the block.

Top module: `strap_seq_top`

## Requirements
- R1: While reset is held, and until the sampling window closes, `cfg_valid_o`, `cfg_gang_o`, `cfg_pwr_high_o`, `cfg_nports_o`, `cfg_fixed_o`, `cfg_clk_o`, `led_oe_o`, all LED pad values and every bit of `pwr_en_o` are 0.
- R2: On the SAMPLE_CYC-th rising clock edge after reset release, all strap pads are latched together and `cfg_valid_o` becomes 1. `cfg_gang_o` takes the gang pad value: 1 selects gang mode and 0 selects per-port mode.
- R3: Once `cfg_valid_o` is 1, no `cfg_*` output changes until the next reset, whatever the strap pads do.
- R4: `cfg_pwr_high_o` is the captured `amber_pad_i[1]` (1 = active-high enable, 0 = active-low enable). After capture, in per-port mode, `pwr_en_o[n]` equals `pwr_req_i[n]` when active-high and its inverse when active-low.
- R5: `cfg_nports_o` decodes {`amber_pad_i[2]`, `amber_pad_i[3]`}: 10 gives 2, 01 gives 3, and both 00 and 11 give NPORT (4 by default).
- R6: `cfg_fixed_o[n]` is 1 exactly when `green_pad_i[n]` was 1 at the capture edge, which marks port n non-removable.
- R7: `cfg_clk_o` decodes `clksel_pad_i`: 01 gives 2 (48 MHz oscillator), 10 gives 1 (27 MHz oscillator), and 11 or 00 give 0 (12 MHz crystal or oscillator).
- R8: `gang_pad_oe_o` is 0 until SWITCH_CYC rising edges have passed since reset release. From then on it stays 1 until reset.
- R9: While it drives, `gang_pad_o` is the inverse of `suspend_i` in per-port mode and equals `suspend_i` in gang mode. While it does not drive, `gang_pad_o` is 0.
- R10: In gang mode, `pwr_en_o[0]` follows `pwr_req_i[0]` in the strapped polarity and every other `pwr_en_o` bit sits at its inactive level. `ovcur_o[n]` is the inverse of `ovcur_n_i[0]` for every port in gang mode, and the inverse of `ovcur_n_i[n]` in per-port mode.
- R11: `led_oe_o` is 0 before capture and 1 after it.
- R12: After capture, `green_pad_o[n]` equals `led_green_i[n]` and `amber_pad_o[n]` equals `led_amber_i[n]` while `suspend_i` is 0. Both are 0 while `suspend_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | Hub is globally suspended |
| gang_pad_i | input | 1 | Gang/per-port strap read from the shared pin |
| gang_pad_oe_o | output | 1 | Output enable for the shared pin |
| gang_pad_o | output | 1 | Suspend indicator driven onto the shared pin |
| clksel_pad_i | input | 2 | Reference clock strap pair |
| green_pad_i | input | NPORT | Green LED pads read as non-removable straps |
| amber_pad_i | input | NPORT-1 (bits NPORT-1:1) | Amber LED pads read as polarity and port-count straps |
| led_oe_o | output | 1 | Output enable for all LED pads |
| green_pad_o | output | NPORT | Green LED drive |
| amber_pad_o | output | NPORT | Amber LED drive |
| led_green_i | input | NPORT | Requested green LED state per port |
| led_amber_i | input | NPORT | Requested amber LED state per port |
| pwr_req_i | input | NPORT | Requested port power, 1 = on |
| pwr_en_o | output | NPORT | Power-switch enables in the strapped polarity |
| ovcur_n_i | input | NPORT | Overcurrent inputs, active low |
| ovcur_o | output | NPORT | Overcurrent flags per port, active high |
| cfg_valid_o | output | 1 | Straps have been captured |
| cfg_gang_o | output | 1 | 1 = gang mode |
| cfg_pwr_high_o | output | 1 | 1 = active-high power enable |
| cfg_nports_o | output | $clog2(NPORT+1) | Number of downstream ports |
| cfg_fixed_o | output | NPORT | Non-removable flag per port |
| cfg_clk_o | output | 2 | Reference clock code |

## Verification
Two events can land on the same edge. In one, the shared pin turns into an output while the hub is already suspended. In the other, the strap pads change just after the capture edge. The bench raises `suspend_i` one cycle before the SWITCH_CYC-th edge. It then compares the first driven value of `gang_pad_o` against the polarity its reference model derived from the captured gang strap. From the cycle after capture on, it scrambles every strap pad and expects each `cfg_*` output to hold the value recorded at the capture edge.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

   typedef enum logic [1:0] {
      REF_XTAL_12M = 2'd0,
      REF_OSC_27M  = 2'd1,
      REF_OSC_48M  = 2'd2
   } ref_clk_e;

   // Strap pair to reference clock; unlisted codes fall back to 12 MHz.
   function automatic ref_clk_e ref_decode(input logic [1:0] code);
      case (code)
         2'b01:   return REF_OSC_48M;
         2'b10:   return REF_OSC_27M;
         default: return REF_XTAL_12M;
      endcase
   endfunction

endpackage

// File: rtl/strap_phase_timer.sv
module strap_phase_timer #(
   parameter int unsigned SAMPLE_CYC = 240,
   parameter int unsigned SWITCH_CYC = 600000
) (
   input  logic clk,
   input  logic rst_n,
   output logic sample_o,
   output logic drive_o
);
   localparam int unsigned CNT_W = $clog2(SWITCH_CYC + 1);
   localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_CYC - 1);
   localparam logic [CNT_W-1:0] SWITCH_AT = CNT_W'(SWITCH_CYC);

   logic [CNT_W-1:0] cnt_q;

   // Counts edges since reset release and saturates at the switch point.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != SWITCH_AT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sample_o = (cnt_q == SAMPLE_AT);
   assign drive_o  = (cnt_q == SWITCH_AT);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_seq_pkg::*;
#(
   parameter int unsigned NPORT = 4,
   parameter int unsigned NP_W  = $clog2(NPORT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_i,
   input  logic             gang_pad_i,
   input  logic [1:0]       clksel_pad_i,
   input  logic [NPORT-1:0] green_pad_i,
   input  logic [3:1]       amber_strap_i,
   output logic             valid_o,
   output logic             gang_o,
   output logic             pol_high_o,
   output logic [NP_W-1:0]  nports_o,
   output logic [NPORT-1:0] fixed_o,
   output ref_clk_e         refclk_o
);
   logic [NP_W-1:0] nports_dec;

   always_comb begin
      case ({amber_strap_i[2], amber_strap_i[3]})
         2'b10:   nports_dec = NP_W'(2);
         2'b01:   nports_dec = NP_W'(3);
         default: nports_dec = NP_W'(NPORT);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o    <= 1'b0;
         gang_o     <= 1'b0;
         pol_high_o <= 1'b0;
         nports_o   <= '0;
         fixed_o    <= '0;
         refclk_o   <= REF_XTAL_12M;
      end else if (sample_i) begin
         valid_o    <= 1'b1;
         gang_o     <= gang_pad_i;
         pol_high_o <= amber_strap_i[1];
         nports_o   <= nports_dec;
         fixed_o    <= green_pad_i;
         refclk_o   <= ref_decode(clksel_pad_i);
      end
   end
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl #(
   parameter int unsigned NPORT = 4
) (
   input  logic             valid_i,
   input  logic             gang_i,
   input  logic             pol_high_i,
   input  logic             suspend_i,
   input  logic [NPORT-1:0] pwr_req_i,
   input  logic [NPORT-1:0] ovcur_n_i,
   input  logic [NPORT-1:0] led_green_i,
   input  logic [NPORT-1:0] led_amber_i,
   output logic [NPORT-1:0] pwr_en_o,
   output logic [NPORT-1:0] ovcur_o,
   output logic [NPORT-1:0] green_pad_o,
   output logic [NPORT-1:0] amber_pad_o
);
   logic led_live;
   assign led_live = valid_i & ~suspend_i;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic on_w;
      if (p == 0) begin : g_lead
         assign on_w = valid_i & pwr_req_i[0];
      end else begin : g_follow
         assign on_w = valid_i & ~gang_i & pwr_req_i[p];
      end
      assign pwr_en_o[p]    = valid_i & (pol_high_i ? on_w : ~on_w);
      assign ovcur_o[p]     = gang_i ? ~ovcur_n_i[0] : ~ovcur_n_i[p];
      assign green_pad_o[p] = led_live & led_green_i[p];
      assign amber_pad_o[p] = led_live & led_amber_i[p];
   end
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
   import strap_seq_pkg::*;
#(
   parameter int unsigned NPORT      = 4,
   parameter int unsigned SAMPLE_CYC = 240,
   parameter int unsigned SWITCH_CYC = 600000,
   localparam int unsigned NP_W      = $clog2(NPORT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             suspend_i,
   input  logic             gang_pad_i,
   output logic             gang_pad_oe_o,
   output logic             gang_pad_o,
   input  logic [1:0]       clksel_pad_i,
   input  logic [NPORT-1:0] green_pad_i,
   input  logic [NPORT-1:1] amber_pad_i,
   output logic             led_oe_o,
   output logic [NPORT-1:0] green_pad_o,
   output logic [NPORT-1:0] amber_pad_o,
   input  logic [NPORT-1:0] led_green_i,
   input  logic [NPORT-1:0] led_amber_i,
   input  logic [NPORT-1:0] pwr_req_i,
   output logic [NPORT-1:0] pwr_en_o,
   input  logic [NPORT-1:0] ovcur_n_i,
   output logic [NPORT-1:0] ovcur_o,
   output logic             cfg_valid_o,
   output logic             cfg_gang_o,
   output logic             cfg_pwr_high_o,
   output logic [NP_W-1:0]  cfg_nports_o,
   output logic [NPORT-1:0] cfg_fixed_o,
   output logic [1:0]       cfg_clk_o
);
   if (NPORT < 4) begin : g_bad_nport
      $error("strap_seq_top: NPORT must be at least 4");
   end
   if (SAMPLE_CYC < 1 || SWITCH_CYC <= SAMPLE_CYC) begin : g_bad_timing
      $error("strap_seq_top: need 1 <= SAMPLE_CYC < SWITCH_CYC");
   end

   logic     sample_w;
   logic     drive_w;
   ref_clk_e refclk_w;

   strap_phase_timer #(
      .SAMPLE_CYC (SAMPLE_CYC),
      .SWITCH_CYC (SWITCH_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_o (sample_w),
      .drive_o  (drive_w)
   );

   strap_capture #(
      .NPORT (NPORT),
      .NP_W  (NP_W)
   ) u_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .sample_i      (sample_w),
      .gang_pad_i    (gang_pad_i),
      .clksel_pad_i  (clksel_pad_i),
      .green_pad_i   (green_pad_i),
      .amber_strap_i (amber_pad_i[3:1]),
      .valid_o       (cfg_valid_o),
      .gang_o        (cfg_gang_o),
      .pol_high_o    (cfg_pwr_high_o),
      .nports_o      (cfg_nports_o),
      .fixed_o       (cfg_fixed_o),
      .refclk_o      (refclk_w)
   );

   port_ctrl #(
      .NPORT (NPORT)
   ) u_ports (
      .valid_i     (cfg_valid_o),
      .gang_i      (cfg_gang_o),
      .pol_high_i  (cfg_pwr_high_o),
      .suspend_i   (suspend_i),
      .pwr_req_i   (pwr_req_i),
      .ovcur_n_i   (ovcur_n_i),
      .led_green_i (led_green_i),
      .led_amber_i (led_amber_i),
      .pwr_en_o    (pwr_en_o),
      .ovcur_o     (ovcur_o),
      .green_pad_o (green_pad_o),
      .amber_pad_o (amber_pad_o)
   );

   assign cfg_clk_o = refclk_w;
   assign led_oe_o  = cfg_valid_o;

   // Shared pin: suspend flag whose sense is set by the strap it gave.
   assign gang_pad_oe_o = drive_w;
   assign gang_pad_o    = drive_w & ~(cfg_gang_o ^ suspend_i);
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
   parameter int unsigned NPORT = 4,
   parameter int unsigned NP_W  = $clog2(NPORT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             suspend_i,
   input logic             cfg_valid_o,
   input logic             cfg_gang_o,
   input logic             cfg_pwr_high_o,
   input logic [NP_W-1:0]  cfg_nports_o,
   input logic [NPORT-1:0] cfg_fixed_o,
   input logic [1:0]       cfg_clk_o,
   input logic             gang_pad_oe_o,
   input logic             gang_pad_o,
   input logic             led_oe_o,
   input logic [NPORT-1:0] green_pad_o,
   input logic [NPORT-1:0] amber_pad_o,
   input logic [NPORT-1:0] pwr_en_o
);
   p_pwr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid_o |-> (pwr_en_o == '0));

   p_valid_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid_o |=> cfg_valid_o);

   p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid_o |=> ($stable(cfg_gang_o) && $stable(cfg_pwr_high_o) &&
                       $stable(cfg_nports_o) && $stable(cfg_fixed_o) &&
                       $stable(cfg_clk_o)));

   p_nports_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid_o |-> (cfg_nports_o >= NP_W'(2) && cfg_nports_o <= NP_W'(NPORT)));

   p_clk_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk_o != 2'd3);

   p_drive_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gang_pad_oe_o |-> cfg_valid_o);

   p_drive_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gang_pad_oe_o |=> gang_pad_oe_o);

   p_awake_sense_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gang_pad_oe_o && !suspend_i) |-> (gang_pad_o == !cfg_gang_o));

   p_sleep_sense_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gang_pad_oe_o && suspend_i) |-> (gang_pad_o == cfg_gang_o));

   p_led_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
      led_oe_o == cfg_valid_o);

   p_led_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_i |-> (green_pad_o == '0 && amber_pad_o == '0));
endmodule

bind strap_seq_top strap_seq_chk #(
   .NPORT (NPORT),
   .NP_W  (NP_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .suspend_i      (suspend_i),
   .cfg_valid_o    (cfg_valid_o),
   .cfg_gang_o     (cfg_gang_o),
   .cfg_pwr_high_o (cfg_pwr_high_o),
   .cfg_nports_o   (cfg_nports_o),
   .cfg_fixed_o    (cfg_fixed_o),
   .cfg_clk_o      (cfg_clk_o),
   .gang_pad_oe_o  (gang_pad_oe_o),
   .gang_pad_o     (gang_pad_o),
   .led_oe_o       (led_oe_o),
   .green_pad_o    (green_pad_o),
   .amber_pad_o    (amber_pad_o),
   .pwr_en_o       (pwr_en_o)
);

// File: tb/strap_seq_top_tb_top.sv
module strap_seq_top_tb_top;
   localparam int NP  = 4;
   localparam int SMP = 12;
   localparam int SW  = 40;
   localparam int NPW = $clog2(NP + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           suspend_i = 1'b0;
   logic           gang_pad_i = 1'b0;
   logic [1:0]     clksel_pad_i = '0;
   logic [NP-1:0]  green_pad_i = '0;
   logic [NP-1:1]  amber_pad_i = '0;
   logic [NP-1:0]  led_green_i = '0, led_amber_i = '0, pwr_req_i = '0;
   logic [NP-1:0]  ovcur_n_i = '1;
   logic           gang_pad_oe_o, gang_pad_o, led_oe_o;
   logic [NP-1:0]  green_pad_o, amber_pad_o, pwr_en_o, ovcur_o, cfg_fixed_o;
   logic           cfg_valid_o, cfg_gang_o, cfg_pwr_high_o;
   logic [NPW-1:0] cfg_nports_o;
   logic [1:0]     cfg_clk_o;

   strap_seq_top #(.NPORT(NP), .SAMPLE_CYC(SMP), .SWITCH_CYC(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i),
      .gang_pad_i(gang_pad_i), .gang_pad_oe_o(gang_pad_oe_o), .gang_pad_o(gang_pad_o),
      .clksel_pad_i(clksel_pad_i), .green_pad_i(green_pad_i), .amber_pad_i(amber_pad_i),
      .led_oe_o(led_oe_o), .green_pad_o(green_pad_o), .amber_pad_o(amber_pad_o),
      .led_green_i(led_green_i), .led_amber_i(led_amber_i),
      .pwr_req_i(pwr_req_i), .pwr_en_o(pwr_en_o),
      .ovcur_n_i(ovcur_n_i), .ovcur_o(ovcur_o),
      .cfg_valid_o(cfg_valid_o), .cfg_gang_o(cfg_gang_o), .cfg_pwr_high_o(cfg_pwr_high_o),
      .cfg_nports_o(cfg_nports_o), .cfg_fixed_o(cfg_fixed_o), .cfg_clk_o(cfg_clk_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Behavioural reference: edge count since release plus the captured straps.
   int          k = 0;
   bit          m_valid = 0, m_gang = 0, m_pol = 0;
   int          m_np = 0, m_clk = 0;
   logic [NP-1:0] m_fixed = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k = 0; m_valid = 0; m_gang = 0; m_pol = 0; m_np = 0; m_clk = 0; m_fixed = '0;
      end else begin
         if (k == SMP - 1) begin
            m_valid = 1;
            m_gang  = gang_pad_i;
            m_pol   = amber_pad_i[1];
            if (amber_pad_i[2] && !amber_pad_i[3]) m_np = 2;
            else if (!amber_pad_i[2] && amber_pad_i[3]) m_np = 3;
            else m_np = NP;
            m_fixed = green_pad_i;
            m_clk   = (clksel_pad_i == 2'b01) ? 2 : (clksel_pad_i == 2'b10) ? 1 : 0;
         end
         if (k < SW) k++;
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         automatic bit drv = rst_n && (k >= SW);
         automatic logic [NP-1:0] e_pwr, e_ov, e_g, e_a;
         automatic string ct = (m_valid && k > SMP) ? "R3" : (m_valid ? "R2" : "R1");
         for (int p = 0; p < NP; p++) begin
            automatic bit on = m_valid && (p == 0 ? pwr_req_i[0] : (!m_gang && pwr_req_i[p]));
            e_pwr[p] = m_valid ? (m_pol ? on : !on) : 1'b0;
            e_ov[p]  = m_gang ? !ovcur_n_i[0] : !ovcur_n_i[p];
            e_g[p]   = m_valid && !suspend_i && led_green_i[p];
            e_a[p]   = m_valid && !suspend_i && led_amber_i[p];
         end
         chk(m_valid ? "R2" : "R1", "cfg_valid", 32'(cfg_valid_o), 32'(m_valid));
         chk(ct, "cfg_gang", 32'(cfg_gang_o), 32'(m_gang));
         chk(m_valid ? "R4" : "R1", "cfg_pwr_high", 32'(cfg_pwr_high_o), 32'(m_pol));
         chk(m_valid ? "R5" : "R1", "cfg_nports", 32'(cfg_nports_o), 32'(m_np));
         chk(m_valid ? "R6" : "R1", "cfg_fixed", 32'(cfg_fixed_o), 32'(m_fixed));
         chk(m_valid ? "R7" : "R1", "cfg_clk", 32'(cfg_clk_o), 32'(m_clk));
         chk("R8", "gang_pad_oe", 32'(gang_pad_oe_o), 32'(drv));
         chk("R9", "gang_pad", 32'(gang_pad_o), 32'(drv ? (m_gang ? suspend_i : !suspend_i) : 1'b0));
         chk(m_gang ? "R10" : (m_valid ? "R4" : "R1"), "pwr_en", 32'(pwr_en_o), 32'(e_pwr));
         chk("R10", "ovcur", 32'(ovcur_o), 32'(e_ov));
         chk("R11", "led_oe", 32'(led_oe_o), 32'(m_valid));
         chk("R12", "green_pad", 32'(green_pad_o), 32'(e_g));
         chk("R12", "amber_pad", 32'(amber_pad_o), 32'(e_a));
      end
   end

   task automatic apply_reset(input bit g, input logic [3:1] am, input logic [3:0] gr,
                              input logic [1:0] cs);
      @(posedge clk); #1;
      rst_n = 1'b0; suspend_i = 1'b0;
      gang_pad_i = g; amber_pad_i = am; green_pad_i = gr; clksel_pad_i = cs;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic run(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(posedge clk); #1;
         pwr_req_i   = NP'($urandom);
         ovcur_n_i   = NP'($urandom);
         led_green_i = NP'($urandom);
         led_amber_i = NP'($urandom);
         if (c >= SMP) begin  // R3: scramble straps after capture
            gang_pad_i = 1'($urandom); amber_pad_i = 3'($urandom);
            green_pad_i = NP'($urandom); clksel_pad_i = 2'($urandom);
         end
         if (c == SW - 2) suspend_i = 1'b1;  // R9: suspended as pin turns
         else if (c > SW + 4) suspend_i = 1'($urandom);
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      apply_reset(1'b0, 3'b001, 4'b1010, 2'b01); run(SW + 30); // 4 ports, high, 48M
      apply_reset(1'b1, 3'b010, 4'b0101, 2'b10); run(SW + 30); // 2 ports, low, 27M
      apply_reset(1'b0, 3'b101, 4'b1111, 2'b11); run(SMP - 3); // R1: aborted window
      apply_reset(1'b0, 3'b101, 4'b1111, 2'b11); run(SW + 30); // 3 ports, 12M
      apply_reset(1'b1, 3'b111, 4'b0000, 2'b00); run(SW + 30); // 11 -> 4 ports, 00 -> 12M
      @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule